// File: doc/BRIEF.md
# One-Shot Countdown Event Timer

This block is a small memory-mapped event timer meant to sit inside a larger peripheral register window. Software arms it by setting a run bit and then writing a tick count; the count starts falling at once, by one on every cycle in which the `tick_en` input is high. When it reaches zero the timer raises a sticky pending flag and stops. It does not reload.

The interrupt line is the pending flag masked by an interrupt-enable bit. Software drops the flag by writing the control word with both the run bit and the clear strobe set. The run bit is the single gate for three things: counting, accepting a new tick value and changing the pending flag. Writing zero to the control word therefore halts the countdown where it stands.

The bus is a plain 32-bit strobe interface. Writes take effect on the rising clock edge. Read data is combinational and valid while `rd_en` is high.

Top module: `oneshot_systimer`

## Requirements
- R1: After reset, the control word and the tick value both read 0 and `irq` is low.
- R2: The control word sits at byte address BASE (default 0x40) with bit 0 = run and bit 1 = interrupt enable, both read back as written. The tick value sits at BASE+4 (0x44). `rdata` is 0 when `rd_en` is low or the address matches neither register.
- R3: A write to the tick value while run is set loads the count and starts the countdown. Reading the tick value returns the remaining count.
- R4: A write to the tick value while run is clear is ignored, and the count keeps its previous value.
- R5: While armed and running, the count falls by exactly one on each clock edge at which `tick_en` is high, and it holds on the other edges.
- R6: Writing 0 to the control word stops the timer, and the count then holds whatever `tick_en` does.
- R7: On the edge at which the count reaches zero, the pending flag sets and the count stays at zero.
- R8: `irq` is high exactly when the pending flag is set and the interrupt enable is 1. Clearing the enable masks `irq` without losing the flag.
- R9: After expiry the timer stays at zero with no reload, whatever further ticks arrive.
- R10: A control write with bit 0 and bit 4 both set clears the pending flag.
- R11: Bit 4 of the control word is a write-only strobe and reads back as 0.
- R12: A control write with bit 4 set but bit 0 clear leaves the pending flag unchanged.
- R13: Loading a tick value of 0 while running sets the pending flag on the following clock edge.
- R14: If expiry and a clearing control write fall on the same edge, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counting-clock enable; one decrement per high cycle |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address within the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt, pending AND interrupt enable |

## Verification
Two events can land on the same clock edge: the expiry that sets the pending flag, and a control write that clears it. The bench loads a count of 1 with ticks held off. It then drives, in the same cycle, a clearing control write together with a single `tick_en` pulse, so both reach the flops at one edge. It judges the result by sampling `irq` with the interrupt enable on: the flag must remain set, and the count must read zero.

// File: rtl/oneshot_systimer.sv
module oneshot_systimer #(
  parameter int ADDR_W = 8,
  parameter int BASE   = 64,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] VAL_A  = ADDR_W'(BASE + 4);
  localparam int RUN_B = 0;
  localparam int IEN_B = 1;
  localparam int CLR_B = 4;

  logic             run_en, irq_en, pending, active, past_ok;
  logic [CNT_W-1:0] count;

  wire sel_ctrl = addr == CTRL_A;
  wire sel_val  = addr == VAL_A;
  wire wr_ctrl  = wr_en && sel_ctrl;
  wire wr_val   = wr_en && sel_val && run_en;
  wire clr      = wr_ctrl && wdata[RUN_B] && wdata[CLR_B];
  wire step     = active && run_en && tick_en;
  wire expire   = !wr_val && active && run_en &&
                  (count == '0 || (count == CNT_W'(1) && tick_en));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en  <= 1'b0;
      irq_en  <= 1'b0;
      pending <= 1'b0;
      active  <= 1'b0;
      count   <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (wr_ctrl) begin
        run_en <= wdata[RUN_B];
        irq_en <= wdata[IEN_B];
      end
      if (wr_val) begin
        count  <= wdata[CNT_W-1:0];
        active <= 1'b1;
      end else if (expire) begin
        count  <= '0;
        active <= 1'b0;
      end else if (step) begin
        count  <= count - CNT_W'(1);
      end
      if (expire)   pending <= 1'b1;
      else if (clr) pending <= 1'b0;
    end
  end

  assign irq = pending && irq_en;

  always_comb begin
    rdata = '0;
    if (rd_en && sel_ctrl) begin
      rdata[RUN_B] = run_en;
      rdata[IEN_B] = irq_en;
    end else if (rd_en && sel_val) begin
      rdata = 32'(count);
    end
  end

  a_r10_clear_only_by_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $fell(pending) |-> $past(wr_en && sel_ctrl && wdata[RUN_B] && wdata[CLR_B]));

  a_r6_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!run_en && !wr_en) |-> $stable(count));

  a_r7_pending_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(pending) |-> count == '0);

  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (count > $past(count)) |-> $past(wr_en && sel_val));

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr_ctrl && !wdata[IEN_B]) |-> !irq);
endmodule

// File: tb/oneshot_systimer_tb.sv
module oneshot_systimer_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        probe = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string req; bit is_irq; } item_t;
  item_t sb[$];

  localparam logic [7:0] CTRL = 8'h40, VAL = 8'h44;

  always #2.5 clk = ~clk;

  oneshot_systimer u_dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always @(negedge clk) begin
    if ((rd_en || probe) && sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1 wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
    sb.push_back('{exp: e, req: r, is_irq: 1'b0});
    @(posedge clk); #1 rd_en = 1'b1; addr = a;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string r);
    sb.push_back('{exp: {31'b0, e}, req: r, is_irq: 1'b1});
    @(posedge clk); #1 probe = 1'b1;
    @(posedge clk); #1 probe = 1'b0;
  endtask

  task automatic tick(input int n);
    @(posedge clk); #1 tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(CTRL, 32'h0, "R1");
    rd(VAL, 32'h0, "R1");
    chk_irq(1'b0, "R1");
    rd(8'h48, 32'h0, "R2");
    wr(VAL, 32'd5);
    rd(VAL, 32'd0, "R4");
    wr(CTRL, 32'h1);
    wr(VAL, 32'd10);
    rd(VAL, 32'd10, "R3");
    tick(3);
    rd(VAL, 32'd7, "R5");
    wr(CTRL, 32'h0);
    tick(4);
    rd(VAL, 32'd7, "R6");
    chk_irq(1'b0, "R6");
    wr(CTRL, 32'h3);
    tick(6);
    rd(VAL, 32'd1, "R5");
    chk_irq(1'b0, "R7");
    tick(1);
    rd(VAL, 32'd0, "R7");
    chk_irq(1'b1, "R8");
    tick(5);
    rd(VAL, 32'd0, "R9");
    chk_irq(1'b1, "R9");
    rd(CTRL, 32'h3, "R2");
    wr(CTRL, 32'h13);
    chk_irq(1'b0, "R10");
    rd(CTRL, 32'h3, "R11");
    wr(VAL, 32'd2);
    tick(2);
    chk_irq(1'b1, "R7");
    wr(CTRL, 32'h12);
    chk_irq(1'b1, "R12");
    wr(CTRL, 32'h01);
    chk_irq(1'b0, "R8");
    wr(CTRL, 32'h03);
    chk_irq(1'b1, "R8");
    wr(CTRL, 32'h13);
    chk_irq(1'b0, "R10");
    wr(VAL, 32'd0);
    chk_irq(1'b1, "R13");
    wr(CTRL, 32'h13);
    chk_irq(1'b0, "R10");
    wr(VAL, 32'd1);
    rd(VAL, 32'd1, "R3");
    @(posedge clk); #1 wr_en = 1'b1; addr = CTRL; wdata = 32'h13; tick_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0; tick_en = 1'b0;
    chk_irq(1'b1, "R14");
    rd(VAL, 32'd0, "R14");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule